// File: doc/BRIEF.md
# Multidrop Bus Slave Protocol Controller

This block is a small control state machine for one slave node on a shared serial line, such as a single-wire bus. It sits above a UART with nine-bit frames. The ninth bit of a frame marks an address frame (1) or a data frame (0). The controller drives the UART's multiprocessor filter bit. While that bit is 1, the UART raises its receive flag only for address frames. While it is 0, every frame gets through.

After reset the node listens for addresses only. When an address frame carries the node's own address, the controller clears the filter and answers with an acknowledge frame. It then takes one task byte from the master and hands it to local logic with a one-cycle strobe. Next it waits for a result byte from that logic, or for a timeout. It transmits the result (or an error code) and sets the filter again.

Every frame this controller transmits has its ninth bit at 0. Only the master addresses nodes.

Top module: `mdrop_slave_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mp_filter` is 1 and `tx_load`, `rx_ack` and `task_strobe` are 0.
- R2: In the listening state, a received frame is consumed (`rx_ack` for one cycle) and ignored when `rx_bit9` is 0 or when `rx_byte` differs from `node_addr`. Ignored means no transmission, no task strobe, and `mp_filter` stays 1.
- R3: An address frame (`rx_bit9`=1) whose byte equals `node_addr` drops `mp_filter` to 0 on the next clock edge. The controller then transmits an acknowledge frame whose byte is `node_addr` and whose ninth bit is 0.
- R4: After the acknowledge, the first data frame (`rx_bit9`=0) is consumed. It raises `task_strobe` for exactly one cycle, with `task_byte` equal to the received byte.
- R5: Counting from the clock edge that accepts the task byte, the controller samples `result_strobe` on the following TIMEOUT edges. At the first of those edges with `result_strobe` high, it latches `result_byte`. It then transmits that value with the ninth bit at 0.
- R6: On the edge that loads the result (or error) frame, the controller returns to the listening state, and `mp_filter` is 1 from then on.
- R7: If `result_strobe` stays low on all TIMEOUT of those edges, the controller transmits ERR_BYTE instead.
- R8: `tx_load` is asserted only while `tx_idle` is 1. The UART treats `tx_load` both as the load command and as the clear of its idle flag. While `tx_idle` stays 0, no frame is sent.
- R9: While waiting for the task byte, an address frame ends the exchange. `mp_filter` returns to 1, and the controller evaluates that frame as an address. If it matches, a new acknowledge is sent and `mp_filter` stays 0.
- R10: `task_strobe` is never asserted while `mp_filter` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 8 | Static address of this node |
| rx_byte | input | 8 | Received frame byte from the UART |
| rx_bit9 | input | 1 | Received ninth bit, 1 = address frame |
| rx_full | input | 1 | UART receive flag, held until cleared |
| rx_ack | output | 1 | One-cycle clear of the receive flag |
| tx_idle | input | 1 | UART transmit flag, 1 = ready for a new frame |
| tx_load | output | 1 | Load the transmit frame; also clears `tx_idle` |
| tx_byte | output | 8 | Transmit frame byte |
| tx_bit9 | output | 1 | Transmit ninth bit (always 0) |
| mp_filter | output | 1 | UART multiprocessor filter enable |
| task_byte | output | 8 | Task byte from the master |
| task_strobe | output | 1 | One-cycle valid for `task_byte` |
| result_byte | input | 8 | Result byte from local logic |
| result_strobe | input | 1 | Valid for `result_byte` |

## Verification
The hardest case to reach is an address frame that arrives while the node is already selected and waiting for its task byte. A correct UART delivers that frame only because the filter is off. The bench's UART model applies the filter from the live `mp_filter` value. It sends a foreign address and then the node's own address into that window, and it also sends unfiltered data frames to a listening node. The timeout boundary is reached by counting edges from the observed task strobe. The result strobe is then placed on the last accepted edge and on the first edge after it.

// File: rtl/mdrop_slave_ctrl.sv
module mdrop_slave_ctrl #(
  parameter int          TIMEOUT  = 1000,
  parameter logic [7:0]  ERR_BYTE = 8'hEE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] node_addr,
  input  logic [7:0] rx_byte,
  input  logic       rx_bit9,
  input  logic       rx_full,
  output logic       rx_ack,
  input  logic       tx_idle,
  output logic       tx_load,
  output logic [7:0] tx_byte,
  output logic       tx_bit9,
  output logic       mp_filter,
  output logic [7:0] task_byte,
  output logic       task_strobe,
  input  logic [7:0] result_byte,
  input  logic       result_strobe
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {LISTEN, ACK, TASK, WAIT, SEND} st_t;
  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic [7:0]    res_q;

  wire addr_hit = rx_bit9 && (rx_byte == node_addr);

  assign mp_filter   = (st == LISTEN);
  assign rx_ack      = rx_full && (st == LISTEN || st == TASK);
  assign task_byte   = rx_byte;
  assign task_strobe = (st == TASK) && rx_full && !rx_bit9;
  assign tx_load     = tx_idle && (st == ACK || st == SEND);
  assign tx_byte     = (st == ACK) ? node_addr : res_q;
  assign tx_bit9     = 1'b0;

  always_comb begin
    st_nx = st;
    case (st)
      LISTEN: if (rx_full && addr_hit) st_nx = ACK;
      ACK:    if (tx_idle) st_nx = TASK;
      TASK:   if (rx_full) begin
                if (!rx_bit9)     st_nx = WAIT;
                else if (addr_hit) st_nx = ACK;
                else               st_nx = LISTEN;
              end
      WAIT:   if (result_strobe || cnt == LAST) st_nx = SEND;
      SEND:   if (tx_idle) st_nx = LISTEN;
      default: st_nx = LISTEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= LISTEN;
      cnt   <= '0;
      res_q <= '0;
    end else begin
      st <= st_nx;
      if (st != WAIT) cnt <= '0;
      else            cnt <= cnt + 1'b1;
      if (st == WAIT) begin
        if (result_strobe)    res_q <= result_byte;
        else if (cnt == LAST) res_q <= ERR_BYTE;
      end
    end
  end
endmodule

module mdrop_slave_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] node_addr,
  input logic [7:0] rx_byte,
  input logic       rx_bit9,
  input logic       rx_full,
  input logic       rx_ack,
  input logic       tx_idle,
  input logic       tx_load,
  input logic       tx_bit9,
  input logic       mp_filter,
  input logic       task_strobe
);
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_load |-> tx_idle); // R8
  AST_TX_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) tx_load |-> !tx_bit9); // R3
  AST_ACK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rx_ack |-> rx_full); // R2
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) task_strobe |-> !mp_filter); // R10
  AST_FILTER_DROP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mp_filter) |-> $past(rx_full && rx_bit9 && rx_byte == node_addr)); // R3
  AST_FILTER_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mp_filter) |-> $past(tx_load || (rx_ack && rx_bit9))); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) task_strobe |=> !task_strobe); // R4
endmodule

bind mdrop_slave_ctrl mdrop_slave_ctrl_chk u_chk (.*);

// File: tb/mdrop_slave_ctrl_test.sv
module mdrop_slave_ctrl_test;
  localparam int         TMO  = 12;
  localparam logic [7:0] ERR  = 8'hE7;
  localparam logic [7:0] ME   = 8'h5A;
  localparam int         TXLAT = 3;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [7:0] rx_byte = 0, result_byte = 0;
  logic rx_bit9 = 0, rx_full = 0, tx_idle = 1, result_strobe = 0;
  logic rx_ack, tx_load, tx_bit9, mp_filter, task_strobe;
  logic [7:0] tx_byte, task_byte;

  mdrop_slave_ctrl #(.TIMEOUT(TMO), .ERR_BYTE(ERR)) uut (
    .clk, .rst_n, .node_addr(ME), .rx_byte, .rx_bit9, .rx_full, .rx_ack,
    .tx_idle, .tx_load, .tx_byte, .tx_bit9, .mp_filter,
    .task_byte, .task_strobe, .result_byte, .result_strobe);

  int errors = 0, checks = 0, cyc = 0;
  int tx_cnt = 0, tv_cnt = 0, tv_cyc = 0, ti_wait = 0;
  logic [7:0] last_tx = 0, last_task = 0;
  logic last_b9 = 0, hold_ti = 0;
  logic dreq = 0, draw = 0, db9 = 0;
  logic [7:0] dbyte = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dreq && (draw || db9 || !mp_filter)) begin
      rx_full <= 1; rx_byte <= dbyte; rx_bit9 <= db9;
    end else if (rx_ack) rx_full <= 0;
    if (tx_load) begin
      tx_cnt <= tx_cnt + 1; last_tx <= tx_byte; last_b9 <= tx_bit9;
      tx_idle <= 0; ti_wait <= TXLAT;
    end else if (ti_wait != 0) ti_wait <= ti_wait - 1;
    else if (!hold_ti) tx_idle <= 1;
    if (task_strobe) begin
      tv_cnt <= tv_cnt + 1; last_task <= task_byte; tv_cyc <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input logic b9, input logic [7:0] b, input logic raw);
    while (rx_full) @(negedge clk);
    dreq = 1; db9 = b9; dbyte = b; draw = raw;
    @(negedge clk);
    dreq = 0; draw = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 200 && tx_cnt < n; i++) @(negedge clk);
  endtask

  task automatic wait_tv(input int n);
    for (int i = 0; i < 200 && tv_cnt < n; i++) @(negedge clk);
  endtask

  task automatic select_me();
    int n;
    n = tx_cnt + 1;
    send(1, ME, 0);
    chk(mp_filter == 0, "R3 filter", mp_filter, 0);
    wait_tx(n);
    chk(tx_cnt == n && last_tx == ME && last_b9 == 0, "R3 ack", last_tx, ME);
  endtask

  task automatic exchange(input logic [7:0] t, input logic [7:0] r, input int dly, input bit give);
    int n, k;
    select_me();
    k = tv_cnt + 1;
    send(0, t, 0);
    wait_tv(k);
    chk(tv_cnt == k && last_task == t, "R4 task", last_task, t);
    n = tx_cnt + 1;
    if (give) begin
      while (cyc < tv_cyc + dly) @(negedge clk);
      result_byte = r; result_strobe = 1;
      @(negedge clk);
      result_strobe = 0;
    end
    wait_tx(n);
    if (give && dly <= TMO)
      chk(tx_cnt == n && last_tx == r && last_b9 == 0, "R5 result", last_tx, r);
    else
      chk(tx_cnt == n && last_tx == ERR && last_b9 == 0, "R7 timeout", last_tx, ERR);
    chk(mp_filter == 1, "R6 relisten", mp_filter, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(mp_filter && !tx_load && !rx_ack && !task_strobe, "R1 in reset", mp_filter, 1);
    rst_n = 1;
    @(negedge clk);
    chk(mp_filter && !tx_load && !rx_ack && !task_strobe, "R1 after reset", mp_filter, 1);

    for (int a = 0; a < 256; a++) begin
      if (a == ME) continue;
      send(1, 8'(a), 0);
      chk(tx_cnt == 0 && mp_filter && !rx_full && tv_cnt == 0, "R2 mismatch", a, ME);
    end
    send(0, ME, 1);
    chk(tx_cnt == 0 && mp_filter && !rx_full, "R2 data while listening", tx_cnt, 0);
    send(0, 8'h33, 1);
    chk(tv_cnt == 0, "R10 no strobe unselected", tv_cnt, 0);

    for (int i = 0; i < 8; i++)
      exchange(8'(17 * i + 3), 8'(29 * i + 1), (i % 4) + 1, 1);
    exchange(8'hA1, 8'h4C, TMO, 1);
    exchange(8'hA2, 8'h4D, TMO + 1, 1);
    exchange(8'hA3, 8'h4E, 0, 0);

    hold_ti = 1;
    repeat (TXLAT + 2) @(negedge clk);
    n = tx_cnt;
    send(1, ME, 0);
    repeat (30) @(negedge clk);
    chk(tx_cnt == n, "R8 held idle", tx_cnt, n);
    hold_ti = 0;
    wait_tx(n + 1);
    chk(tx_cnt == n + 1 && last_tx == ME, "R8 sent after idle", last_tx, ME);

    send(1, 8'h11, 0);
    chk(mp_filter == 1, "R9 abandon", mp_filter, 1);
    n = tv_cnt;
    send(0, 8'h77, 0);
    chk(tv_cnt == n && !rx_full, "R9 data filtered", tv_cnt, n);
    select_me();
    n = tx_cnt + 1;
    send(1, ME, 0);
    wait_tx(n);
    chk(tx_cnt == n && last_tx == ME && mp_filter == 0, "R9 reselect", last_tx, ME);
    n = tv_cnt + 1;
    send(0, 8'h99, 0);
    wait_tv(n);
    chk(tv_cnt == n && last_task == 8'h99, "R9 task after reselect", last_task, 8'h99);
    n = tx_cnt + 1;
    wait_tx(n);
    chk(last_tx == ERR && mp_filter == 1, "R7 after reselect", last_tx, ERR);

    finish_run();
  end
endmodule